// File: doc/BRIEF.md
# Device Datapool Snapshot Reader

This block serves host reads of one device's register image out of a larger per-device datapool. The host writes a device selector, a node ID in the upper bits and a service access point in the lower four bits, over a 24-bit register bus. The reader then asserts a lock toward the pool-side updater and copies that device's words into a private snapshot store. When the copy is done it releases the lock and clears its 16-bit address pointer. The host can then set the pointer and read words one after another. The pointer steps forward on every data read.

Every read carries a status byte in bits [23:16]: bit 23 is the valid flag, bit 22 is the busy flag, and bits [21:16] mirror the `err_status` input. The valid flag comes from the pool's per-device valid bit, sampled when the copy starts. An invalidate strobe for the selected device clears it until the device is selected again. The pool itself is outside this block. It answers a read address one cycle later and reports the device's word count and valid bit combinationally for `pool_dev`.

Top module: `dsr_snapshot_reader`

## Requirements
- R1: After reset the selector and the pointer are zero, `pool_lock` is low, the snapshot length is zero and the valid flag is clear.
- R2: A write to register 0 loads the selector from `bus_wdata[11:0]` and clears the pointer. `pool_lock` then stays high for exactly L+2 cycles, where L is the clamped word count. `pool_rd_en` is only ever high while `pool_lock` is high.
- R3: While the copy runs, every read sets bit 22 and clears bit 23. A data read (register 2) returns 16'hFFFF in bits [15:0] and leaves the pointer unchanged.
- R4: When no copy is running, a data read at pointer P < L returns snapshot word P in bits [15:0] and the valid flag in bit 23. Bits [21:16] always show `err_status`.
- R5: A data read with no copy running increments the 16-bit pointer, wrapping from 16'hFFFF to 0. Reads of the other registers do not move it.
- R6: A write to register 1 loads the pointer from `bus_wdata[15:0]`. A read of register 1 returns the pointer in bits [15:0].
- R7: A read of register 0 returns the selector in bits [11:0] with bits [15:12] zero. On reads of registers 0, 1 and 3, bit 23 is the valid flag gated off while busy.
- R8: A data read at a pointer at or beyond L returns 16'hFFFF with bit 23 clear, and still advances the pointer.
- R9: Data reads return the words captured during the copy. Later changes to the live pool do not appear until the next selector write.
- R10: An `inval_stb` whose `inval_dev` equals the current selector clears the valid flag until the next selector write. An invalidate for any other device has no effect.
- R11: A selector write during a copy abandons that copy and starts a fresh one for the new device. The lock window is counted again from that write.
- R12: Register 3 is unmapped. Writes to it change nothing, and a read of it returns 16'hFFFF in bits [15:0] without moving the pointer.
- R13: The word count taken from `pool_len` is clamped to 64. Pointers 64 and above read as out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects) |
| bus_addr | input | 2 | Register index: 0 selector, 1 pointer, 2 data, 3 unmapped |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr`, combinational |
| err_status | input | 6 | Error status shown in bits [21:16] |
| inval_stb | input | 1 | Invalidate event strobe |
| inval_dev | input | 12 | Device targeted by the invalidate |
| pool_dev | output | 12 | Device whose pool region is addressed |
| pool_lock | output | 1 | Stalls the pool updater while copying |
| pool_rd_en | output | 1 | Pool word read request |
| pool_rd_addr | output | 6 | Word index within the device region |
| pool_rd_data | input | 16 | Pool word, valid one cycle after the request |
| pool_len | input | 8 | Word count of `pool_dev` |
| pool_dev_valid | input | 1 | Valid bit of `pool_dev` |

## Verification
The hardest case to reach from the ports is a copy that is in flight when something else lands on it. That means a selector rewrite while read requests are still in the pool pipeline, or data and invalidate traffic overlapping the lock window. The stimulus fires a second selector write a few cycles into a long copy and issues data reads while the lock is up. It changes the live pool only after the copy has finished. A cycle-level model counts each lock window and holds its own snapshot, so any stale word, an early unlock, or a pointer step taken while busy shows up on the very next compare.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int BUS_W   = 24;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = 12;
    localparam int ERR_W   = 6;
    localparam int LEN_W   = 8;
    localparam int SNAP_DEPTH = 64;
    localparam int IDX_W   = $clog2(SNAP_DEPTH);
    localparam int CNT_W   = $clog2(SNAP_DEPTH + 1);

    typedef enum logic [1:0] {
        REG_SEL  = 2'd0,
        REG_PTR  = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CP_IDLE  = 2'd0,
        CP_START = 2'd1,
        CP_COPY  = 2'd2
    } cp_state_e;

    typedef struct packed {
        logic             valid;
        logic             busy;
        logic [ERR_W-1:0] err;
    } hi_byte_t;

    typedef struct packed {
        hi_byte_t          hi;
        logic [DATA_W-1:0] lo;
    } bus_word_t;

    function automatic logic [CNT_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        if (l > LEN_W'(SNAP_DEPTH))
            return CNT_W'(SNAP_DEPTH);
        return CNT_W'(l);
    endfunction
endpackage

// File: rtl/dsr_snap_mem.sv
module dsr_snap_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dsr_copy_ctrl.sv
module dsr_copy_ctrl
    import dsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    input  logic             inval_stb,
    input  logic [SEL_W-1:0] inval_dev,
    input  logic [LEN_W-1:0] pool_len,
    input  logic             pool_dev_valid,
    output logic             busy,
    output logic             pool_rd_en,
    output logic [IDX_W-1:0] pool_rd_addr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] len_q,
    output logic             snap_valid
);
    cp_state_e        state;
    logic [CNT_W-1:0] iss;
    logic             pend;
    logic [IDX_W-1:0] pend_idx;
    logic             issuing;

    assign issuing      = (state == CP_COPY) && (iss < len_q);
    assign busy         = (state != CP_IDLE);
    assign pool_rd_en   = issuing;
    assign pool_rd_addr = iss[IDX_W-1:0];
    assign wr_en        = pend;
    assign wr_idx       = pend_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CP_IDLE;
            iss        <= '0;
            pend       <= 1'b0;
            pend_idx   <= '0;
            len_q      <= '0;
            snap_valid <= 1'b0;
        end else begin
            pend <= issuing && !start;
            if (start) begin
                state <= CP_START;
                iss   <= '0;
            end else begin
                unique case (state)
                    CP_START: begin
                        len_q      <= clamp_len(pool_len);
                        snap_valid <= pool_dev_valid;
                        iss        <= '0;
                        state      <= CP_COPY;
                    end
                    CP_COPY: begin
                        if (iss == len_q) begin
                            state <= CP_IDLE;
                        end else begin
                            iss      <= iss + CNT_W'(1);
                            pend_idx <= iss[IDX_W-1:0];
                        end
                    end
                    default: state <= CP_IDLE;
                endcase
            end
            if (inval_stb && (inval_dev == sel))
                snap_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dsr_host_regs.sv
module dsr_host_regs
    import dsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [ERR_W-1:0]  err_status,
    input  logic              busy,
    input  logic [CNT_W-1:0]  len_q,
    input  logic              snap_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              start,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DATA_W-1:0] ptr_q,
    output logic [BUS_W-1:0]  bus_rdata
);
    reg_sel_e  rsel;
    logic      in_range;
    logic      data_rd;
    bus_word_t word;
    logic      unused_wdata;

    assign rsel         = reg_sel_e'(bus_addr);
    assign start        = bus_wr && (rsel == REG_SEL);
    assign data_rd      = bus_rd && !bus_wr && (rsel == REG_DATA) && !busy;
    assign in_range     = ptr_q < {{(DATA_W-CNT_W){1'b0}}, len_q};
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            ptr_q <= '0;
        end else if (start) begin
            sel_q <= bus_wdata[SEL_W-1:0];
            ptr_q <= '0;
        end else if (bus_wr && (rsel == REG_PTR)) begin
            ptr_q <= bus_wdata[DATA_W-1:0];
        end else if (data_rd) begin
            ptr_q <= ptr_q + DATA_W'(1);
        end
    end

    always_comb begin
        word.hi.err   = err_status;
        word.hi.busy  = busy;
        word.hi.valid = snap_valid && !busy;
        word.lo       = '1;
        unique case (rsel)
            REG_SEL: word.lo = {{(DATA_W-SEL_W){1'b0}}, sel_q};
            REG_PTR: word.lo = ptr_q;
            REG_DATA: begin
                if (!busy && in_range)
                    word.lo = mem_rdata;
                else
                    word.hi.valid = 1'b0;
            end
            default: word.lo = '1;
        endcase
    end

    assign bus_rdata = word;
endmodule

// File: rtl/dsr_snapshot_reader.sv
module dsr_snapshot_reader
    import dsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [ERR_W-1:0]  err_status,
    input  logic              inval_stb,
    input  logic [SEL_W-1:0]  inval_dev,
    output logic [SEL_W-1:0]  pool_dev,
    output logic              pool_lock,
    output logic              pool_rd_en,
    output logic [IDX_W-1:0]  pool_rd_addr,
    input  logic [DATA_W-1:0] pool_rd_data,
    input  logic [LEN_W-1:0]  pool_len,
    input  logic              pool_dev_valid
);
    logic              start;
    logic              copy_busy;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] ptr_q;
    logic [CNT_W-1:0]  len_q;
    logic              snap_valid;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] mem_rdata;

    assign pool_dev  = sel_q;
    assign pool_lock = copy_busy;

    dsr_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .err_status (err_status),
        .busy       (copy_busy),
        .len_q      (len_q),
        .snap_valid (snap_valid),
        .mem_rdata  (mem_rdata),
        .start      (start),
        .sel_q      (sel_q),
        .ptr_q      (ptr_q),
        .bus_rdata  (bus_rdata)
    );

    dsr_copy_ctrl u_copy (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .sel            (sel_q),
        .inval_stb      (inval_stb),
        .inval_dev      (inval_dev),
        .pool_len       (pool_len),
        .pool_dev_valid (pool_dev_valid),
        .busy           (copy_busy),
        .pool_rd_en     (pool_rd_en),
        .pool_rd_addr   (pool_rd_addr),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .len_q          (len_q),
        .snap_valid     (snap_valid)
    );

    dsr_snap_mem #(
        .DEPTH (SNAP_DEPTH),
        .WIDTH (DATA_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (pool_rd_data),
        .rd_idx  (ptr_q[IDX_W-1:0]),
        .rd_data (mem_rdata)
    );
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
    import dsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              pool_lock,
    input logic              pool_rd_en,
    input logic              busy,
    input logic [DATA_W-1:0] ptr,
    input logic [CNT_W-1:0]  len_q
);
    logic unused_rdata;
    assign unused_rdata = ^bus_rdata;

    assert_sel_lock_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> pool_lock);

    assert_sel_ptr_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> (ptr == '0));

    assert_rden_locked_R2: assert property (@(posedge clk) disable iff (rst)
        pool_rd_en |-> pool_lock);

    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_rd && !bus_wr && bus_addr == 2'd2) |=> (ptr == $past(ptr)));

    assert_busy_flag_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bus_rdata[22] && !bus_rdata[23]));

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_rd && !bus_wr && bus_addr == 2'd2)
        |=> (ptr == DATA_W'($past(ptr) + DATA_W'(1))));

    assert_out_of_range_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_addr == 2'd2 && ptr >= {{(DATA_W-CNT_W){1'b0}}, len_q})
        |-> (bus_rdata[15:0] == 16'hFFFF && !bus_rdata[23]));

    assert_len_clamp_R13: assert property (@(posedge clk) disable iff (rst)
        len_q <= CNT_W'(SNAP_DEPTH));
endmodule

bind dsr_snapshot_reader dsr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pool_lock  (pool_lock),
    .pool_rd_en (pool_rd_en),
    .busy       (copy_busy),
    .ptr        (ptr_q),
    .len_q      (len_q)
);

// File: tb/tb_dsr_snapshot_reader.sv
`timescale 1ns/1ps
module tb_dsr_snapshot_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [23:0] bus_wdata = '0;
    logic [23:0] bus_rdata;
    logic [5:0]  err_status = '0;
    logic        inval_stb = 1'b0;
    logic [11:0] inval_dev = '0;
    logic [11:0] pool_dev;
    logic        pool_lock;
    logic        pool_rd_en;
    logic [5:0]  pool_rd_addr;
    logic [15:0] pool_rd_data = '0;
    logic [7:0]  pool_len;
    logic        pool_dev_valid;

    always #10 clk = ~clk;

    dsr_snapshot_reader dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_status(err_status), .inval_stb(inval_stb), .inval_dev(inval_dev),
        .pool_dev(pool_dev), .pool_lock(pool_lock), .pool_rd_en(pool_rd_en),
        .pool_rd_addr(pool_rd_addr), .pool_rd_data(pool_rd_data),
        .pool_len(pool_len), .pool_dev_valid(pool_dev_valid)
    );

    // live pool model
    logic [7:0] gen = 8'h00;

    function automatic logic [15:0] pool_word(input logic [11:0] d, input int a, input logic [7:0] g);
        return {d[7:0] ^ g, 2'b00, 6'(a)};
    endfunction

    assign pool_len       = pool_dev[7:0];
    assign pool_dev_valid = !pool_dev[11];

    always @(posedge clk)
        if (pool_rd_en) pool_rd_data <= pool_word(pool_dev, int'(pool_rd_addr), gen);

    // reference model
    int          m_sel, m_ptr, m_cnt, m_len;
    bit          m_valid;
    int          m_snap [64];
    int          n_cmp = 0, n_bad = 0;
    string       phase = "R1";
    bit          done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_ptr = 0; m_cnt = 0; m_len = 0; m_valid = 0;
        end else begin
            automatic bit was_busy = (m_cnt > 0);
            if (inval_stb && int'(inval_dev) == m_sel) m_valid = 0;
            if (bus_wr && bus_addr == 2'd0) begin
                m_sel = int'(bus_wdata[11:0]);
                m_ptr = 0;
                m_len = (m_sel % 256 > 64) ? 64 : m_sel % 256;
                m_cnt = m_len + 2;
                m_valid = (m_sel < 2048);
                for (int i = 0; i < m_len; i++)
                    m_snap[i] = int'(pool_word(12'(m_sel), i, gen));
            end else begin
                if (m_cnt > 0) m_cnt--;
                if (bus_wr && bus_addr == 2'd1) m_ptr = int'(bus_wdata[15:0]);
                else if (bus_rd && !bus_wr && bus_addr == 2'd2 && !was_busy)
                    m_ptr = (m_ptr + 1) % 65536;
            end
        end
    end

    function automatic logic [23:0] exp_rdata();
        logic busy;
        logic v;
        logic [15:0] lo;
        busy = (m_cnt > 0);
        v = m_valid && !busy;
        case (bus_addr)
            2'd0: lo = 16'(m_sel);
            2'd1: lo = 16'(m_ptr);
            2'd2: begin
                if (!busy && m_ptr < m_len) lo = 16'(m_snap[m_ptr]);
                else begin lo = 16'hFFFF; v = 1'b0; end
            end
            default: lo = 16'hFFFF;
        endcase
        return {v, busy, err_status, lo};
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            automatic logic [23:0] e = exp_rdata();
            automatic logic el = (m_cnt > 0);
            n_cmp += 2;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s rdata addr=%0d got=%h exp=%h t=%0t", phase, bus_addr, bus_rdata, e, $time);
            end
            if (pool_lock !== el) begin
                n_bad++;
                $display("FAIL %s pool_lock got=%b exp=%b t=%0t", phase, pool_lock, el, $time);
            end
        end
    end

    task automatic op(input logic w, input logic r, input logic [1:0] a, input logic [23:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic inval(input logic [11:0] d);
        inval_stb = 1'b1; inval_dev = d;
        @(posedge clk); #1;
        inval_stb = 1'b0;
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b1, 2'd2, '0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state via every register
        phase = "R1";
        err_status = 6'h15;
        op(1'b0, 1'b1, 2'd0, '0);
        op(1'b0, 1'b1, 2'd1, '0);
        op(1'b0, 1'b1, 2'd2, '0);
        idle(1);
        // R2 / R3: select a 10-word device, read while busy
        phase = "R2";
        op(1'b1, 1'b0, 2'd0, 24'h00A);
        phase = "R3";
        reads(4);
        idle(10);
        // R4 / R5 / R8: walk the snapshot and beyond it
        phase = "R4";
        err_status = 6'h2A;
        reads(10);
        phase = "R8";
        reads(3);
        // R6: pointer load and readback
        phase = "R6";
        op(1'b1, 1'b0, 2'd1, 24'h000003);
        op(1'b0, 1'b1, 2'd1, '0);
        phase = "R5";
        reads(2);
        op(1'b0, 1'b1, 2'd0, '0);
        op(1'b1, 1'b0, 2'd1, 24'h00FFFF);
        reads(2);
        // R7: selector readback
        phase = "R7";
        op(1'b0, 1'b1, 2'd0, '0);
        // R9: live pool changes after the copy
        phase = "R9";
        gen = 8'h33;
        op(1'b1, 1'b0, 2'd1, 24'h0);
        reads(5);
        // R10: invalidate another device, then the selected one
        phase = "R10";
        inval(12'h00B);
        op(1'b1, 1'b0, 2'd1, 24'h0);
        reads(2);
        inval(12'h00A);
        op(1'b1, 1'b0, 2'd1, 24'h0);
        reads(2);
        op(1'b0, 1'b1, 2'd1, '0);
        // R11: reselect during a copy
        phase = "R11";
        op(1'b1, 1'b0, 2'd0, 24'h014);
        idle(4);
        op(1'b1, 1'b0, 2'd0, 24'h007);
        reads(2);
        idle(10);
        reads(8);
        // R13: clamp of an 80-word device
        phase = "R13";
        op(1'b1, 1'b0, 2'd0, 24'h050);
        idle(70);
        op(1'b1, 1'b0, 2'd1, 24'h00003C);
        reads(6);
        // R12: unmapped register
        phase = "R12";
        op(1'b1, 1'b0, 2'd3, 24'hFFFFFF);
        op(1'b0, 1'b1, 2'd3, '0);
        op(1'b0, 1'b1, 2'd1, '0);
        op(1'b0, 1'b1, 2'd0, '0);
        // R2: zero-length device with its valid bit clear
        phase = "R2";
        gen = 8'h5C;
        op(1'b1, 1'b0, 2'd0, 24'h800);
        idle(3);
        reads(2);
        op(1'b0, 1'b1, 2'd0, '0);
        // R10: invalidate during the lock window
        phase = "R10";
        op(1'b1, 1'b0, 2'd0, 24'h006);
        inval(12'h006);
        idle(8);
        reads(7);
        idle(2);
        finish_run();
    end
endmodule